// File: doc/BRIEF.md
# Two-Mode Switch Input Port Controller

This block runs one input port of a two-stage, load-balanced packet switch. The port's link into the middle stage rotates over the middle nodes in a fixed cyclic order. The block tracks which middle node is connected in the current slot and keeps an occupancy counter for each destination queue. In every slot it decides whether the port sends nothing, a contention packet, or a reservation packet. It also chooses the destination queue that supplies the packet. Packet payloads live elsewhere. This controller only issues the send strobe, the mode flag and the queue index for the payload store and the fabric.

A reservation frame can begin only in the slot in which the port faces middle node 0. The frame needs at least one queue holding a full frame, which is as many packets as there are ports. The frame then occupies the port for that many consecutive slots, and nothing downstream can refuse it. In every other slot the port offers one packet from a non-empty queue. That contention send goes ahead only if three conditions hold: the connected middle node's current buffer location is free, no global block is raised, and the chosen output is not individually blocked. Each slot is one clock cycle. Decisions are combinational from registered state and the current inputs, and state advances on the rising edge that closes the slot.

Top module: `dmi_port_ctl`

## Requirements
- R1: `mid_idx` equals (`PORT_ID` + `slot`) mod `N_PORTS` in the same cycle, for every slot value.
- R2: A reservation frame starts only in a slot where `mid_idx` is 0 and at least one queue counter is at least `N_PORTS`. Its first packet is sent in that same slot with `send`=1 and `send_resv`=1 (1 means reservation, 0 means contention).
- R3: Each selection picks the requesting index closest to the pointer, scanning upward from the pointer with wrap-around, and the pointer then becomes the chosen index plus one (mod `N_PORTS`). For example, with 6 ports, requests at indices 1 and 3 and the pointer at 4, index 1 is chosen and the pointer becomes 2. Reservation and contention keep separate pointers, and each pointer moves only when its own kind of send is made.
- R4: Once started, a frame sends `N_PORTS` consecutive reservation packets from the same queue. This holds whatever the values of `cb_free`, `gblock` and `iblock`.
- R5: Outside a frame, if any eligible queue is non-empty and sending is allowed, one contention packet (`send`=1, `send_resv`=0) is sent from the round-robin choice among the eligible queues.
- R6: No contention packet is sent in a slot where `cb_free` is 0.
- R7: No contention packet is sent in a slot where `gblock` is 1.
- R8: A queue j with `iblock[j]`=1 is never chosen for contention. An unblocked non-empty queue is still served in that slot.
- R9: A queue counter rises by one for an arrival (`arr_valid`=1, binary queue index on `arr_dest`) and falls by one for a send from that queue. When both happen in the same slot the counter is unchanged. An arrival first counts toward decisions in the following slot.
- R10: After reset all counters are 0, both pointers are 0 and no frame is active, so `send` is 0 until packets arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock, one cycle per slot |
| rst_n | input | 1 | Active-low asynchronous reset |
| arr_valid | input | 1 | A packet arrives this slot |
| arr_dest | input | $clog2(N_PORTS) | Destination queue of the arriving packet |
| slot | input | SLOT_W | Global slot counter |
| cb_free | input | 1 | The connected middle node's current contention location is empty |
| gblock | input | 1 | Global hold on all contention sends |
| iblock | input | N_PORTS | Per-output hold on contention sends, bit j for output j |
| send | output | 1 | A packet leaves the port this slot |
| send_resv | output | 1 | 1 for reservation, 0 for contention |
| send_dest | output | $clog2(N_PORTS) | Queue the packet is taken from |
| mid_idx | output | $clog2(N_PORTS) | Middle node connected this slot |

## Verification
Two functions can land in the same cycle: an arrival into a queue, and a departure from that same queue. The bench provokes this by offering an arrival to a queue in the very slot in which that queue is being served. It does this for both contention sends and reservation frames. The result is judged by the number and order of later sends, which must match a bench-side occupancy count. A second collision comes at the middle-node-0 slot. Both a full queue and an eligible contention queue are present there, and the reservation must win.

// File: rtl/dmi_pkg.sv
package dmi_pkg;

   // per-slot decision taken by the port
   typedef enum logic [1:0] {
      DEC_IDLE       = 2'd0,
      DEC_CONTENTION = 2'd1,
      DEC_FRAME_HEAD = 2'd2,
      DEC_FRAME_BODY = 2'd3
   } dec_e;

   function automatic logic dec_is_send(input dec_e d);
      return d != DEC_IDLE;
   endfunction

   function automatic logic dec_is_resv(input dec_e d);
      return (d == DEC_FRAME_HEAD) || (d == DEC_FRAME_BODY);
   endfunction

endpackage

// File: rtl/dmi_rr_pick.sv
module dmi_rr_pick #(
   parameter int N_REQ = 4,
   localparam int IW = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
   input  logic [N_REQ-1:0] req,
   input  logic [IW-1:0]    ptr,
   output logic             hit,
   output logic [IW-1:0]    sel,
   output logic [IW-1:0]    nxt
);

   always_comb begin
      int idx;
      hit = 1'b0;
      sel = '0;
      // scan from farthest to nearest so the nearest request wins
      for (int k = N_REQ - 1; k >= 0; k--) begin
         idx = (int'(ptr) + k) % N_REQ;
         if (req[idx]) begin
            hit = 1'b1;
            sel = IW'(idx);
         end
      end
      nxt = (int'(sel) == N_REQ - 1) ? '0 : sel + IW'(1);
   end

endmodule

// File: rtl/dmi_voq_bank.sv
module dmi_voq_bank #(
   parameter int N_Q   = 4,
   parameter int CNT_W = 5,
   localparam int IW   = $clog2(N_Q)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          inc_v,
   input  logic [IW-1:0] inc_idx,
   input  logic          dec_v,
   input  logic [IW-1:0] dec_idx,
   output logic [N_Q-1:0] nonempty,
   output logic [N_Q-1:0] frame_ready
);

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   for (genvar g = 0; g < N_Q; g++) begin : g_q
      logic [CNT_W-1:0] cnt_q;
      logic             up;
      logic             dn;

      assign up = inc_v && (int'(inc_idx) == g);
      assign dn = dec_v && (int'(dec_idx) == g);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt_q <= '0;
         end else if (up && !dn) begin
            if (cnt_q != CNT_MAX) cnt_q <= cnt_q + CNT_W'(1);
         end else if (dn && !up) begin
            cnt_q <= cnt_q - CNT_W'(1);
         end
      end

      assign nonempty[g]    = (cnt_q != '0);
      assign frame_ready[g] = (32'(cnt_q) >= N_Q);
   end

endmodule

// File: rtl/dmi_port_ctl.sv
module dmi_port_ctl #(
   parameter int N_PORTS = 4,
   parameter int PORT_ID = 1,
   parameter int SLOT_W  = 8,
   parameter int CNT_W   = 5,
   localparam int DW     = $clog2(N_PORTS)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               arr_valid,
   input  logic [DW-1:0]      arr_dest,
   input  logic [SLOT_W-1:0]  slot,
   input  logic               cb_free,
   input  logic               gblock,
   input  logic [N_PORTS-1:0] iblock,
   output logic               send,
   output logic               send_resv,
   output logic [DW-1:0]      send_dest,
   output logic [DW-1:0]      mid_idx
);
   import dmi_pkg::*;

   if (N_PORTS < 2) begin : g_bad_n
      $error("N_PORTS must be at least 2");
   end
   if (PORT_ID < 0 || PORT_ID >= N_PORTS) begin : g_bad_id
      $error("PORT_ID out of range");
   end
   if (SLOT_W < 1 || SLOT_W > 30) begin : g_bad_slot
      $error("SLOT_W must be 1..30");
   end
   if ((1 << CNT_W) <= N_PORTS) begin : g_bad_cnt
      $error("CNT_W too narrow to hold a full frame");
   end

   localparam logic [DW-1:0] LAST_LEFT = DW'(N_PORTS - 1);

   // frame state
   logic [DW-1:0] left_q;
   logic [DW-1:0] fdest_q;
   logic [DW-1:0] rptr_q;
   logic [DW-1:0] cptr_q;

   logic [N_PORTS-1:0] nonempty;
   logic [N_PORTS-1:0] frame_ready;
   logic [N_PORTS-1:0] cont_req;
   logic               r_hit, c_hit;
   logic [DW-1:0]      r_sel, r_nxt, c_sel, c_nxt;
   logic               in_frame;
   dec_e               dec;

   // cyclic first-stage connection
   assign mid_idx = DW'((32'(PORT_ID) + 32'(slot)) % 32'(N_PORTS));

   assign in_frame = (left_q != '0);
   assign cont_req = nonempty & ~iblock & {N_PORTS{~gblock}};

   dmi_rr_pick #(.N_REQ(N_PORTS)) u_rsel (
      .req (frame_ready),
      .ptr (rptr_q),
      .hit (r_hit),
      .sel (r_sel),
      .nxt (r_nxt)
   );

   dmi_rr_pick #(.N_REQ(N_PORTS)) u_csel (
      .req (cont_req),
      .ptr (cptr_q),
      .hit (c_hit),
      .sel (c_sel),
      .nxt (c_nxt)
   );

   always_comb begin
      if (in_frame)                         dec = DEC_FRAME_BODY;
      else if (mid_idx == '0 && r_hit)      dec = DEC_FRAME_HEAD;
      else if (c_hit && cb_free)            dec = DEC_CONTENTION;
      else                                  dec = DEC_IDLE;
   end

   always_comb begin
      unique case (dec)
         DEC_FRAME_BODY: send_dest = fdest_q;
         DEC_FRAME_HEAD: send_dest = r_sel;
         DEC_CONTENTION: send_dest = c_sel;
         default:        send_dest = '0;
      endcase
   end

   assign send      = dec_is_send(dec);
   assign send_resv = dec_is_resv(dec);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         left_q  <= '0;
         fdest_q <= '0;
         rptr_q  <= '0;
         cptr_q  <= '0;
      end else begin
         unique case (dec)
            DEC_FRAME_HEAD: begin
               left_q  <= LAST_LEFT;
               fdest_q <= r_sel;
               rptr_q  <= r_nxt;
            end
            DEC_FRAME_BODY: left_q <= left_q - DW'(1);
            DEC_CONTENTION: cptr_q <= c_nxt;
            default: ;
         endcase
      end
   end

   dmi_voq_bank #(.N_Q(N_PORTS), .CNT_W(CNT_W)) u_bank (
      .clk         (clk),
      .rst_n       (rst_n),
      .inc_v       (arr_valid),
      .inc_idx     (arr_dest),
      .dec_v       (send),
      .dec_idx     (send_dest),
      .nonempty    (nonempty),
      .frame_ready (frame_ready)
   );

endmodule

// File: rtl/dmi_port_ctl_chk.sv
module dmi_port_ctl_chk #(
   parameter int N_PORTS = 4,
   localparam int DW     = $clog2(N_PORTS)
) (
   input logic               clk,
   input logic               rst_n,
   input logic               cb_free,
   input logic               gblock,
   input logic [N_PORTS-1:0] iblock,
   input logic               send,
   input logic               send_resv,
   input logic [DW-1:0]      send_dest,
   input logic [DW-1:0]      mid_idx
);

   // R2: a reservation away from node 0 must continue a frame of the same queue
   a_r2_frame_continues: assert property (@(posedge clk) disable iff (!rst_n)
      (send && send_resv && mid_idx != '0) |->
         ($past(send && send_resv) && $past(send_dest) == send_dest));

   // R4: a frame not yet at its last node carries on next slot, unrefused
   a_r4_frame_unbroken: assert property (@(posedge clk) disable iff (!rst_n)
      (send && send_resv && mid_idx != DW'(N_PORTS - 1)) |=>
         (send && send_resv && $stable(send_dest)));

   // R6
   a_r6_needs_free: assert property (@(posedge clk) disable iff (!rst_n)
      (send && !send_resv) |-> cb_free);

   // R7
   a_r7_global_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (send && !send_resv) |-> !gblock);

   // R8
   a_r8_output_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (send && !send_resv) |-> !iblock[send_dest]);

endmodule

bind dmi_port_ctl dmi_port_ctl_chk #(.N_PORTS(N_PORTS)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cb_free   (cb_free),
   .gblock    (gblock),
   .iblock    (iblock),
   .send      (send),
   .send_resv (send_resv),
   .send_dest (send_dest),
   .mid_idx   (mid_idx)
);

// File: tb/sim_dmi_port_ctl.sv
`timescale 1ns/1ps
module sim_dmi_port_ctl;
   localparam int N  = 4;
   localparam int ID = 1;
   localparam int SW = 8;
   localparam int CW = 5;
   localparam int DW = $clog2(N);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          arr_valid = 1'b0;
   logic [DW-1:0] arr_dest = '0;
   logic [SW-1:0] slot = '0;
   logic          cb_free = 1'b0;
   logic          gblock = 1'b0;
   logic [N-1:0]  iblock = '0;
   logic          send, send_resv;
   logic [DW-1:0] send_dest, mid_idx;

   always #2 clk = ~clk;

   dmi_port_ctl #(.N_PORTS(N), .PORT_ID(ID), .SLOT_W(SW), .CNT_W(CW)) u0 (
      .clk(clk), .rst_n(rst_n), .arr_valid(arr_valid), .arr_dest(arr_dest),
      .slot(slot), .cb_free(cb_free), .gblock(gblock), .iblock(iblock),
      .send(send), .send_resv(send_resv), .send_dest(send_dest), .mid_idx(mid_idx)
   );

   typedef struct {
      bit    s;
      bit    r;
      int    d;
      int    m;
      string tag;
   } exp_t;

   exp_t q[$];
   exp_t e;
   int   n_cmp = 0;
   int   n_bad = 0;

   // reference state built from the requirements
   int m_cnt[N];
   int m_rptr = 0, m_cptr = 0, m_left = 0, m_fdest = 0;
   int slot_n = 0;

   function automatic int rr(input bit [N-1:0] req, input int ptr);
      for (int k = 0; k < N; k++) begin
         if (req[(ptr + k) % N]) return (ptr + k) % N;
      end
      return -1;
   endfunction

   task automatic step(input bit av, input int ad, input bit fr, input bit gb,
                       input bit [N-1:0] ib, input string tag);
      exp_t x;
      bit [N-1:0] full, elig;
      int p;
      @(negedge clk);
      x.s = 0; x.r = 0; x.d = 0; x.tag = tag;
      x.m = (ID + (slot_n % (1 << SW))) % N;
      for (int j = 0; j < N; j++) begin
         full[j] = (m_cnt[j] >= N);
         elig[j] = (m_cnt[j] > 0) && !ib[j] && !gb;
      end
      if (m_left > 0) begin
         x.s = 1; x.r = 1; x.d = m_fdest; m_left--;
      end else if (x.m == 0 && full != 0) begin
         p = rr(full, m_rptr);
         x.s = 1; x.r = 1; x.d = p;
         m_fdest = p; m_left = N - 1; m_rptr = (p + 1) % N;
      end else if (fr && elig != 0) begin
         p = rr(elig, m_cptr);
         x.s = 1; x.r = 0; x.d = p; m_cptr = (p + 1) % N;
      end
      if (x.s) m_cnt[x.d]--;
      if (av && m_cnt[ad] < (1 << CW) - 1) m_cnt[ad]++;
      q.push_back(x);
      slot      = SW'(slot_n);
      arr_valid = av;
      arr_dest  = DW'(ad);
      cb_free   = fr;
      gblock    = gb;
      iblock    = ib;
      slot_n++;
   endtask

   task automatic idle(input int n, input bit fr, input bit gb,
                       input bit [N-1:0] ib, input string tag);
      for (int i = 0; i < n; i++) step(0, 0, fr, gb, ib, tag);
   endtask

   // monitor: compare popped expectations against the ports
   always @(negedge clk) begin
      #1;
      if (q.size() > 0) begin
         e = q.pop_front();
         n_cmp++;
         if (send !== e.s || (e.s && (send_resv !== e.r || send_dest !== DW'(e.d)))) begin
            n_bad++;
            $display("FAIL %s: send=%0b resv=%0b dest=%0d expected send=%0b resv=%0b dest=%0d",
                     e.tag, send, send_resv, send_dest, e.s, e.r, e.d);
         end
         n_cmp++;
         if (mid_idx !== DW'(e.m)) begin
            n_bad++;
            $display("FAIL R1: mid_idx=%0d expected %0d", mid_idx, e.m);
         end
      end
   end

   initial begin
      #(4 * 150000);
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      for (int j = 0; j < N; j++) m_cnt[j] = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R10 reset state, R1 connection rotates
      idle(3, 1, 0, '0, "R10");

      // R5 / R9: arrival seen next slot, then a contention send
      step(1, 2, 1, 0, '0, "R9");
      idle(2, 1, 0, '0, "R5");

      // R6: no contention while the location is occupied
      step(1, 0, 0, 0, '0, "R6");
      idle(2, 0, 0, '0, "R6");
      idle(1, 1, 0, '0, "R6");

      // R7 global hold, then R8 masking keeps queue 2 eligible
      step(1, 1, 0, 0, '0, "R7");
      step(1, 2, 0, 0, '0, "R7");
      idle(2, 1, 1, '0, "R7");
      idle(1, 1, 0, 4'b0010, "R8");
      idle(2, 1, 0, '0, "R8");

      // R3: contention round robin over queues 0, 2, 3
      step(1, 3, 0, 1, '0, "R3");
      step(1, 0, 0, 1, '0, "R3");
      step(1, 2, 0, 1, '0, "R3");
      idle(4, 1, 0, '0, "R3");

      // R9: arrival and departure on the same queue in one slot
      step(1, 1, 0, 1, '0, "R9");
      step(1, 1, 1, 0, '0, "R9");
      idle(3, 1, 0, '0, "R9");

      // R2 / R4: a full frame on queue 3, unrefusable under every hold
      for (int i = 0; i < 5; i++) step(1, 3, 0, 1, '0, "R2");
      idle(8, 0, 1, '1, "R4");

      // R3 reservation pointer: queues 0 and 2 both full, plus same-slot arrivals
      for (int i = 0; i < 4; i++) begin
         step(1, 0, 0, 1, '0, "R3");
         step(1, 2, 0, 1, '0, "R3");
      end
      step(1, 1, 1, 0, '0, "R2");
      idle(12, 1, 0, '0, "R4");

      // drain what is left, mixing holds
      idle(4, 1, 0, 4'b0100, "R8");
      idle(10, 1, 0, '0, "R5");

      @(negedge clk);
      #3;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule